// File: doc/BRIEF.md
# Audio Frame Step Sequencer with Interrupt Flag

This block paces the slow envelope, sweep and length logic of a sound unit. It runs from the CPU clock and counts through a fixed sequence of step points. At each step it drives a one-cycle quarter-frame pulse. On selected steps it also drives a half-frame pulse. Two sequence lengths are offered: a four-step sequence of `PERIOD` cycles and a five-step sequence of `PERIOD*5/4` cycles. The step points are spread evenly across each sequence.

In the four-step sequence the block can raise an interrupt flag once per pass, at the last step. The flag is held as a level on `irq_req` until software acknowledges it. There are two ways to acknowledge it: a status read strobe, or a control write that sets the inhibit bit. A control write that changes only the mode leaves a pending flag in place. Every control write, and every warm restart, sends the step counter back to the start of its sequence.

Top module: `apu_frame_seq`

## Requirements
- R1: In four-step mode with the inhibit bit clear, the flag rises once every `PERIOD` cycles. Counting the restarting edge as edge 0, the flag is first visible after edge `PERIOD`.
- R2: The control byte uses bit 7 for the mode (0 = four-step, 1 = five-step) and bit 6 for the inhibit. The five-step mode never sets the flag, and neither does a set inhibit bit.
- R3: A `stat_rd` strobe clears the flag at its clock edge. A control write with bit 6 set also clears it.
- R4: A control write with bit 6 clear (0x00 or 0x80) does not clear a pending flag.
- R5: After `rst_n` the block is in four-step mode with interrupts enabled, the flag is clear and the counter is at the start. With no write, the flag is therefore set within `PERIOD`+3 cycles of reset release.
- R6: `irq_req` is a level. It stays high for any length of time until one of the clearing events of R3 or R11 occurs.
- R7: `status` carries the flag at bit 6, and all other bits are 0. It reads 0x40 while the flag is pending and 0x00 otherwise.
- R8: A control write restarts the step counter at the start of the sequence. Any step or flag event that falls in the write cycle is dropped.
- R9: Let N be the number of steps and L the length of the sequence. Counting the restarting edge as edge 0, `qtr_tick` pulses for one cycle after edge k*L/N, for each k from 1 to N, and the pattern repeats every L cycles. `half_tick` pulses together with steps 2 and 4 in four-step mode, and with steps 2 and 5 in five-step mode.
- R10: If the flag is set and cleared in the same cycle, the set takes priority.
- R11: A `warm_rst` pulse restarts the counter and clears the flag. It leaves the mode and inhibit bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| warm_rst | input | 1 | Synchronous restart strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control byte: bit 7 mode, bit 6 inhibit |
| stat_rd | input | 1 | Status read strobe; acknowledges the flag |
| status | output | 8 | Status byte with the flag at bit 6 |
| irq_req | output | 1 | Level interrupt request |
| qtr_tick | output | 1 | Quarter-frame step pulse |
| half_tick | output | 1 | Half-frame step pulse |

## Verification
A counter that holds a wrong value shows up quickly as shifted quarter pulses. The shift is visible within one step spacing of a restart, and the bench counts pulses over fixed windows that start at a control write. A wrong mode or inhibit bit shows up as an unexpected half-pulse count, or as a flag rising in a pass that should leave it low, within one sequence length. A wrong flag-clearing path shows up one cycle after the strobe, either as `irq_req` surviving an acknowledge or as `irq_req` dropping after a mode-only write. The bench checks both cases, including a read that lands on the exact edge where the flag is set.

// File: rtl/apu_fs_pkg.sv
package apu_fs_pkg;
  typedef enum logic {SEQ_FOUR = 1'b0, SEQ_FIVE = 1'b1} seq_mode_e;

  typedef struct packed {
    seq_mode_e mode;
    logic      inhibit;
  } fs_ctrl_t;

  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned INH_BIT  = 6;
  localparam int unsigned FLAG_BIT = 6;

  function automatic int unsigned step_point(input int unsigned len,
                                             input int unsigned nsteps,
                                             input int unsigned k);
    return (k * len) / nsteps - 1;
  endfunction
endpackage

// File: rtl/fs_rst_sync.sv
module fs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fs_ctrl_reg.sv
module fs_ctrl_reg
  import apu_fs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_mode,
  input  logic     wr_inhibit,
  output fs_ctrl_t ctrl
);
  fs_ctrl_t ctrl_d, ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.mode    = seq_mode_e'(wr_mode);
      ctrl_d.inhibit = wr_inhibit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.mode    <= SEQ_FOUR;
      ctrl_q.inhibit <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/fs_step_timer.sv
module fs_step_timer
  import apu_fs_pkg::*;
#(
  parameter int unsigned PERIOD = 29830
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  seq_mode_e mode,
  output logic      qtr_hit,
  output logic      half_hit,
  output logic      seq_end4
);
  localparam int unsigned LEN4 = PERIOD;
  localparam int unsigned LEN5 = (PERIOD * 5) / 4;
  localparam int unsigned CW   = $clog2(LEN5 + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [4:0]    hit4, hit5;
  logic          wrap;

  // step point decoders for both sequence lengths
  for (genvar k = 1; k <= 5; k++) begin : g_pts
    if (k <= 4) begin : g_four
      localparam int unsigned P4 = step_point(LEN4, 4, k);
      assign hit4[k-1] = (cnt_q == CW'(P4));
    end else begin : g_none
      assign hit4[k-1] = 1'b0;
    end
    localparam int unsigned P5 = step_point(LEN5, 5, k);
    assign hit5[k-1] = (cnt_q == CW'(P5));
  end

  always_comb begin
    if (mode == SEQ_FIVE) wrap = (cnt_q == CW'(LEN5 - 1));
    else                  wrap = (cnt_q == CW'(LEN4 - 1));

    if (restart)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_comb begin
    qtr_hit  = 1'b0;
    half_hit = 1'b0;
    seq_end4 = 1'b0;
    if (!restart) begin
      if (mode == SEQ_FIVE) begin
        qtr_hit  = |hit5;
        half_hit = hit5[1] | hit5[4];
      end else begin
        qtr_hit  = |hit4;
        half_hit = hit4[1] | hit4[3];
        seq_end4 = hit4[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fs_irq_flag.sv
module fs_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  logic flag_d, flag_q;

  always_comb begin
    if (set_req)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/apu_frame_seq.sv
module apu_frame_seq
  import apu_fs_pkg::*;
#(
  parameter int unsigned PERIOD = 29830
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warm_rst,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_data,
  input  logic       stat_rd,
  output logic [7:0] status,
  output logic       irq_req,
  output logic       qtr_tick,
  output logic       half_tick
);
  logic     rst_int_n;
  fs_ctrl_t ctrl;
  logic     restart, qtr_hit, half_hit, seq_end4;
  logic     set_req, clr_req, flag;
  logic     qtr_q, half_q;
  logic     unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_data[5:0];

  fs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fs_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (ctrl_wr),
    .wr_mode    (ctrl_data[MODE_BIT]),
    .wr_inhibit (ctrl_data[INH_BIT]),
    .ctrl       (ctrl)
  );

  assign restart = ctrl_wr | warm_rst;

  fs_step_timer #(.PERIOD(PERIOD)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .restart  (restart),
    .mode     (ctrl.mode),
    .qtr_hit  (qtr_hit),
    .half_hit (half_hit),
    .seq_end4 (seq_end4)
  );

  assign set_req = seq_end4 & ~ctrl.inhibit;
  assign clr_req = stat_rd | warm_rst | (ctrl_wr & ctrl_data[INH_BIT]);

  fs_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .flag    (flag)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      qtr_q  <= qtr_hit;
      half_q <= half_hit;
    end
  end

  assign qtr_tick  = qtr_q;
  assign half_tick = half_q;
  assign irq_req   = flag;

  always_comb begin
    status           = 8'h00;
    status[FLAG_BIT] = flag;
  end
endmodule

// File: rtl/apu_frame_seq_chk.sv
module apu_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       warm_rst,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_data,
  input logic       stat_rd,
  input logic [7:0] status,
  input logic       irq_req,
  input logic       qtr_tick,
  input logic       half_tick
);
  // R6 / R4: the flag only drops after an acknowledge or warm restart
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> $past(stat_rd || warm_rst || (ctrl_wr && ctrl_data[6])));

  // R1 / R2: the flag only rises together with a half step pulse
  assert_flag_on_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> half_tick);

  // R2: an inhibiting write cannot be followed by a new flag
  assert_inhibit_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[6]) |=> !irq_req);

  // R9: half pulses are a subset of quarter pulses, and pulses are single cycle
  assert_half_in_qtr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> qtr_tick);
  assert_qtr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);

  // R7: status carries the flag at bit 6 only
  assert_status_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == {1'b0, irq_req, 6'b0}));
endmodule

bind apu_frame_seq apu_frame_seq_chk u_chk (.*);

// File: tb/apu_frame_seq_test.sv
`timescale 1ns/1ps
module apu_frame_seq_test;
  localparam int unsigned PER = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic       stat_rd = 1'b0;
  logic [7:0] status;
  logic       irq_req, qtr_tick, half_tick;

  int checks = 0;
  int errors = 0;
  int nq, nh;
  bit done = 1'b0;

  always #4 clk = ~clk;

  apu_frame_seq #(.PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .ctrl_wr(ctrl_wr),
    .ctrl_data(ctrl_data), .stat_rd(stat_rd), .status(status),
    .irq_req(irq_req), .qtr_tick(qtr_tick), .half_tick(half_tick));

  // vector: [24] irq, [23:20] halves, [19:16] quarters, [15:8] cycles, [7:0] control
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 4'd2, 4'd4,  8'd40,  8'h00},
    {1'b0, 4'd1, 4'd3,  8'd39,  8'h00},
    {1'b0, 4'd2, 4'd4,  8'd45,  8'h40},
    {1'b0, 4'd2, 4'd5,  8'd50,  8'h80},
    {1'b0, 4'd4, 4'd10, 8'd100, 8'h80},
    {1'b1, 4'd4, 4'd8,  8'd80,  8'h00},
    {1'b0, 4'd2, 4'd5,  8'd50,  8'hC0},
    {1'b0, 4'd1, 4'd2,  8'd20,  8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    nq = 0; nh = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nq += int'(qtr_tick);
      nh += int'(half_tick);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d, input bit rd);
    ctrl_wr = 1'b1; ctrl_data = d; stat_rd = rd;
    @(negedge clk);
    ctrl_wr = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset irq", int'(irq_req), 0);
    check("R7 reset status", int'(status), 0);
    check("R9 reset tick", int'(qtr_tick), 0);
    rst_n = 1'b1;
    // R5: default four-step enabled, flag after about PER cycles
    run(30);
    check("R5 no early flag", int'(irq_req), 0);
    run(15);
    check("R5 power-up flag", int'(irq_req), 1);
    check("R7 status pending", int'(status), 8'h40);

    // vector table walk (R1 R2 R9)
    for (int v = 0; v < 8; v++) begin
      wr_ctrl(VEC[v][7:0], 1'b1);
      run(int'(VEC[v][15:8]));
      check("R9 quarter count", nq, int'(VEC[v][19:16]));
      check("R9 half count", nh, int'(VEC[v][23:20]));
      check("R1 R2 flag", int'(irq_req), int'(VEC[v][24]));
    end

    // R4 and R6: mode writes keep the flag, no decay
    wr_ctrl(8'h00, 1'b1);
    run(40);
    check("R1 set", int'(irq_req), 1);
    wr_ctrl(8'h80, 1'b0);
    run(200);
    check("R4 write 80 keeps flag", int'(irq_req), 1);
    wr_ctrl(8'h00, 1'b0);
    run(5);
    check("R4 write 00 keeps flag", int'(irq_req), 1);
    check("R6 level", int'(irq_req), 1);

    // R3: status read clears
    rd_stat();
    check("R3 read clears", int'(irq_req), 0);
    check("R7 status clear", int'(status), 0);

    // R3: write with bit 6 clears
    wr_ctrl(8'h00, 1'b0);
    run(40);
    check("R1 set again", int'(irq_req), 1);
    wr_ctrl(8'h40, 1'b0);
    check("R3 write 40 clears", int'(irq_req), 0);

    // R10: read on the set edge loses to the set
    wr_ctrl(8'h00, 1'b0);
    run(39);
    rd_stat();
    check("R10 set wins", int'(irq_req), 1);
    rd_stat();

    // R8: a rewrite restarts the count
    wr_ctrl(8'h00, 1'b0);
    run(30);
    wr_ctrl(8'h00, 1'b0);
    run(39);
    check("R8 restart delays flag", int'(irq_req), 0);
    run(1);
    check("R8 flag after full period", int'(irq_req), 1);

    // R11: warm restart clears flag, keeps five-step mode
    wr_ctrl(8'h80, 1'b0);
    run(10);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    check("R11 warm clears flag", int'(irq_req), 0);
    run(45);
    check("R11 mode kept half count", nh, 1);
    check("R11 quarter count", nq, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule